// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block sits between a set of interrupt-capable devices and a processor core. Each device presents a ready flag, an interrupt-enable flag and a fixed priority level. The block considers only devices with both flags set. Among those it picks the one with the most urgent level, and it compares that level with the level of the program now running on the core.

When the chosen device outranks the running program, the block raises a request line. The core reacts only at instruction boundaries, between the store of one instruction and the fetch of the next. For that reason the block also produces a one-cycle take pulse, which it emits only in a cycle where the core reports such a boundary. The winner's level and index are presented so the core can see which device won.

The gate is a three-state machine. `ARB_IDLE` means no pending request outranks the program. `ARB_WAIT` means an outranking request is waiting for a boundary. `ARB_TAKE` is the single cycle in which the take pulse is out. The transitions are:
- idle to wait, when a request outranks the program and there is no boundary.
- idle or wait to take, when a request outranks the program and there is a boundary.
- wait to idle, when the request is withdrawn or no longer outranks the program.
- take to wait or to idle, according to whether a request still outranks the program. Take never repeats on the next cycle.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `irq_req`, `irq_take`, `win_level` and `win_index` are all zero.
- R2: Device i takes part only when both `dev_ready[i]` and `dev_ie[i]` are 1. A device with only one of the two flags set has no effect on any output.
- R3: Level 7 is the most urgent and level 0 the least. Among the qualified devices, the one with the numerically largest level is reported on `win_level` and `win_index`. Device i's level is `dev_level[3*i +: 3]`.
- R4: When several qualified devices share the largest level, the lowest device index wins.
- R5: `irq_req` is 1 exactly when the winner's level is strictly greater than `cur_level`. An equal level does not raise it.
- R6: With no qualified device, `irq_req` is 0 and `win_level` and `win_index` are 0.
- R7: `irq_take` is 1 only in the cycle after an edge where `insn_boundary` was 1 and a qualified request outranked `cur_level`. Without a boundary, or without an outranking request, it stays 0.
- R8: `irq_take` is never 1 in two consecutive cycles. With the boundary held high and the request kept, pulses come every second cycle.
- R9: A request withdrawn before a boundary returns the block to idle. A later boundary then produces no take pulse.
- R10: All outputs are registered. Inputs sampled at a rising edge appear on the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_ready | input | 8 | Per-device ready flag |
| dev_ie | input | 8 | Per-device interrupt enable |
| dev_level | input | 24 | Per-device 3-bit priority, device i at bits 3*i+2:3*i |
| cur_level | input | 3 | Priority level of the running program |
| insn_boundary | input | 1 | High in a cycle where the core sits between store and next fetch |
| irq_req | output | 1 | Winning request outranks the running program |
| irq_take | output | 1 | One-cycle pulse telling the core to enter the handler |
| win_level | output | 3 | Level of the winning device, zero when none |
| win_index | output | 3 | Index of the winning device, zero when none |

## Verification
The assertions assume that `cur_level`, the request flags and `insn_boundary` are stable around each rising edge. They also assume that these inputs hold known values from reset onward, because the checks compare the registered outputs with the inputs sampled one edge earlier. The stimulus changes inputs only on the falling edge and holds every input at zero during reset. Device levels are also written on the falling edge, so every comparison is made against settled values.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_TAKE = 2'd2
    } arb_state_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int NUM_DEV = 8
) (
    input  logic [NUM_DEV-1:0] ready_i,
    input  logic [NUM_DEV-1:0] enable_i,
    output logic [NUM_DEV-1:0] req_o
);

    // A device counts only when both its flags are set.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_qual
        assign req_o[d] = ready_i[d] & enable_i[d];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_DEV = 8,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_DEV-1:0]       req_i,
    input  logic [NUM_DEV*LVL_W-1:0] level_i,
    output logic                     found_o,
    output logic [LVL_W-1:0]         best_lvl_o,
    output logic [IDX_W-1:0]         best_idx_o
);

    // Linear chain: stage d holds the best candidate among devices below d.
    logic [NUM_DEV:0]            chain_found;
    logic [NUM_DEV:0][LVL_W-1:0] chain_lvl;
    logic [NUM_DEV:0][IDX_W-1:0] chain_idx;

    assign chain_found[0] = 1'b0;
    assign chain_lvl[0]   = '0;
    assign chain_idx[0]   = '0;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_stage
        logic [LVL_W-1:0] my_lvl;
        logic             beats;
        assign my_lvl = level_i[d*LVL_W +: LVL_W];
        // Strictly greater: an equal level keeps the earlier, lower index.
        assign beats  = req_i[d] & (~chain_found[d] | (my_lvl > chain_lvl[d]));
        assign chain_found[d+1] = chain_found[d] | req_i[d];
        assign chain_lvl[d+1]   = beats ? my_lvl : chain_lvl[d];
        assign chain_idx[d+1]   = beats ? IDX_W'(d) : chain_idx[d];
    end

    assign found_o    = chain_found[NUM_DEV];
    assign best_lvl_o = chain_lvl[NUM_DEV];
    assign best_idx_o = chain_idx[NUM_DEV];

endmodule

// File: rtl/irq_gate_fsm.sv
module irq_gate_fsm
    import irqarb_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             found_i,
    input  logic [LVL_W-1:0] best_lvl_i,
    input  logic [IDX_W-1:0] best_idx_i,
    input  logic [LVL_W-1:0] cur_level_i,
    input  logic             boundary_i,
    output logic             irq_req_o,
    output logic             irq_take_o,
    output logic [LVL_W-1:0] win_level_o,
    output logic [IDX_W-1:0] win_index_o
);

    arb_state_t state_q, state_nxt;
    logic       outranks;

    assign outranks = found_i && (best_lvl_i > cur_level_i);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (outranks && boundary_i)      state_nxt = ARB_TAKE;
                else if (outranks)               state_nxt = ARB_WAIT;
            end
            ARB_WAIT: begin
                if (!outranks)                   state_nxt = ARB_IDLE;
                else if (boundary_i)             state_nxt = ARB_TAKE;
            end
            ARB_TAKE: begin
                state_nxt = outranks ? ARB_WAIT : ARB_IDLE;
            end
            default:                             state_nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req_o   <= 1'b0;
            irq_take_o  <= 1'b0;
            win_level_o <= '0;
            win_index_o <= '0;
        end else begin
            irq_req_o   <= outranks;
            irq_take_o  <= (state_nxt == ARB_TAKE);
            win_level_o <= found_i ? best_lvl_i : '0;
            win_index_o <= found_i ? best_idx_i : '0;
        end
    end

    assert_take_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> ($past(boundary_i) && irq_req_o));

    assert_take_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |=> !irq_take_o);

    assert_req_outranks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (win_level_o > $past(cur_level_i)));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(found_i) |-> (win_level_o == '0 && win_index_o == '0 && !irq_req_o));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irqarb_pkg::*;
#(
    parameter int NUM_DEV = 8,
    parameter int LVL_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_DEV-1:0]       dev_ready,
    input  logic [NUM_DEV-1:0]       dev_ie,
    input  logic [NUM_DEV*LVL_W-1:0] dev_level,
    input  logic [LVL_W-1:0]         cur_level,
    input  logic                     insn_boundary,
    output logic                     irq_req,
    output logic                     irq_take,
    output logic [LVL_W-1:0]         win_level,
    output logic [idx_width(NUM_DEV)-1:0] win_index
);

    localparam int IDX_W = idx_width(NUM_DEV);

    logic [NUM_DEV-1:0] req_vec;
    logic               found;
    logic [LVL_W-1:0]   best_lvl;
    logic [IDX_W-1:0]   best_idx;

    irq_qualify #(.NUM_DEV(NUM_DEV)) u_qualify (
        .ready_i  (dev_ready),
        .enable_i (dev_ie),
        .req_o    (req_vec)
    );

    irq_prio_pick #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
        .req_i      (req_vec),
        .level_i    (dev_level),
        .found_o    (found),
        .best_lvl_o (best_lvl),
        .best_idx_o (best_idx)
    );

    irq_gate_fsm #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .found_i     (found),
        .best_lvl_i  (best_lvl),
        .best_idx_i  (best_idx),
        .cur_level_i (cur_level),
        .boundary_i  (insn_boundary),
        .irq_req_o   (irq_req),
        .irq_take_o  (irq_take),
        .win_level_o (win_level),
        .win_index_o (win_index)
    );

    // The picked device must be qualified and carry the reported level.
    assert_pick_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (dev_ready[best_idx] && dev_ie[best_idx]
                   && dev_level[best_idx*LVL_W +: LVL_W] == best_lvl));

endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] dev_ready, dev_ie;
    logic [23:0] dev_level;
    logic [2:0] cur_level;
    logic       insn_boundary;
    logic       irq_req, irq_take;
    logic [2:0] win_level, win_index;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_arbiter u_irq_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .dev_ie(dev_ie),
        .dev_level(dev_level), .cur_level(cur_level), .insn_boundary(insn_boundary),
        .irq_req(irq_req), .irq_take(irq_take), .win_level(win_level), .win_index(win_index)
    );

    // Device levels: d7=2 d6=5 d5=5 d4=1 d3=6 d2=6 d1=0 d0=3
    localparam logic [23:0] LEVELS = {3'd2, 3'd5, 3'd5, 3'd1, 3'd6, 3'd6, 3'd0, 3'd3};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, then sample just after the next rising edge.
    task automatic step(input logic [7:0] rdy, input logic [7:0] ie,
                        input logic [2:0] cur, input logic bnd);
        @(negedge clk);
        dev_ready = rdy; dev_ie = ie; cur_level = cur; insn_boundary = bnd;
        @(posedge clk); #1;
    endtask

    task automatic expect_out(input string tag, input int rq, input int tk,
                              input int lv, input int ix);
        check({tag, " irq_req"},   int'(irq_req),   rq);
        check({tag, " irq_take"},  int'(irq_take),  tk);
        check({tag, " win_level"}, int'(win_level), lv);
        check({tag, " win_index"}, int'(win_index), ix);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; dev_ready = '0; dev_ie = '0; dev_level = LEVELS;
        cur_level = '0; insn_boundary = 1'b0;
        repeat (3) @(posedge clk);
        #1 expect_out("R1 in reset", 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 expect_out("R1 after reset", 0, 0, 0, 0);
    endtask

    task automatic t_qualify;
        step(8'h08, 8'h20, 3'd0, 1'b0);   // single flags only
        expect_out("R2 half flags", 0, 0, 0, 0);
        step(8'h00, 8'h00, 3'd0, 1'b0);
        expect_out("R6 no request", 0, 0, 0, 0);
        step(8'h08, 8'h08, 3'd0, 1'b0);
        expect_out("R2 both flags", 1, 0, 6, 3);
    endtask

    task automatic t_highest;
        step(8'h51, 8'h51, 3'd0, 1'b0);   // devs 0,4,6 -> levels 3,1,5
        expect_out("R3 highest", 1, 0, 5, 6);
        step(8'h13, 8'h13, 3'd0, 1'b0);   // devs 0,1,4 -> levels 3,0,1
        expect_out("R3 mixed", 1, 0, 3, 0);
    endtask

    task automatic t_tie;
        step(8'h60, 8'h60, 3'd0, 1'b0);   // devs 5,6 both level 5
        expect_out("R4 tie 5/6", 1, 0, 5, 5);
        step(8'hFF, 8'hFF, 3'd0, 1'b0);   // devs 2,3 level 6
        expect_out("R4 tie all", 1, 0, 6, 2);
    endtask

    task automatic t_compare;
        step(8'h40, 8'h40, 3'd5, 1'b0);
        expect_out("R5 equal level", 0, 0, 5, 6);
        step(8'h40, 8'h40, 3'd4, 1'b0);
        expect_out("R5 greater level", 1, 0, 5, 6);
        step(8'h02, 8'h02, 3'd0, 1'b0);   // level 0 never outranks
        expect_out("R5 level zero", 0, 0, 0, 1);
    endtask

    task automatic t_boundary;
        step(8'h00, 8'h00, 3'd0, 1'b0);
        step(8'h40, 8'h40, 3'd4, 1'b0);
        expect_out("R7 wait no boundary", 1, 0, 5, 6);
        step(8'h40, 8'h40, 3'd4, 1'b1);
        expect_out("R7 take", 1, 1, 5, 6);
        step(8'h40, 8'h40, 3'd4, 1'b1);
        expect_out("R8 no back-to-back", 1, 0, 5, 6);
        step(8'h40, 8'h40, 3'd4, 1'b1);
        expect_out("R8 second pulse", 1, 1, 5, 6);
        step(8'h40, 8'h40, 3'd7, 1'b1);
        expect_out("R7 not outranking", 0, 0, 5, 6);
        step(8'h00, 8'h00, 3'd0, 1'b1);
        expect_out("R7 boundary no request", 0, 0, 0, 0);
    endtask

    task automatic t_withdraw;
        step(8'h08, 8'h08, 3'd2, 1'b0);
        expect_out("R9 pending", 1, 0, 6, 3);
        step(8'h08, 8'h00, 3'd2, 1'b0);
        expect_out("R9 withdrawn", 0, 0, 0, 0);
        step(8'h08, 8'h00, 3'd2, 1'b1);
        expect_out("R9 later boundary", 0, 0, 0, 0);
        step(8'h08, 8'h08, 3'd2, 1'b1);   // registered path: R10
        expect_out("R10 one-edge latency", 1, 1, 6, 3);
    endtask

    initial begin
        t_reset;
        t_qualify;
        t_highest;
        t_tie;
        t_compare;
        t_boundary;
        t_withdraw;
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule